// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block holds the interrupt state of a small processor core: a 32-bit pending word, a 32-bit enable word, and the processor status word. The status word carries the current interrupt level, an exception-mode flag and a user-mode flag. Each cycle the block looks at every interrupt that is both pending and enabled, finds the highest level among them, and decides whether that level may interrupt the core. When it may, the block pulses a take strobe and reports the level and the entry vector. On the next clock edge it updates the status word, the cause code and, for levels above one, the per-level saved state.

Level-1 interrupts are blocked while the exception-mode flag is set. On entry they set that flag, leave the level field alone and record cause 4. They enter through the user vector when the user-mode flag is set and through the kernel vector otherwise. Higher levels save the old status word and a return address into registers private to that level, and raise the level field to their own. A return command for such a level restores the status from its saved copy and presents the saved return address.

The core reaches the block through several paths. A register write port and a register read port reach the pending-set, pending-clear, enable, status, saved-state and cause registers. A level-raise command hands back the old status word. Software can also issue a return command and a wait-for-interrupt request, and the block reports whether the core is still stalled in that wait.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000001F, and the pending, enable and cause registers read 0. The status word holds the level in bits 3:0, the exception-mode flag in bit 4 and the user-mode flag in bit 5. It is read and written with register select 3.
- R2: A level-raise command presents the whole current status word on `raise_old` in the same cycle. At the next edge it replaces bits 3:0 with the requested level and keeps every other status bit.
- R3: Writing a mask with select 0 sets those pending bits, and writing a mask with select 1 clears them. Reading select 0 or 1 returns exactly the pending bits that are set. Select 2 writes and reads the enable word.
- R4: A pending interrupt whose enable bit is clear never causes a take, and it leaves the status word unchanged.
- R5: The highest pending and enabled level L is taken only when L is greater than the current level field. A level-1 interrupt also needs the exception-mode flag to be clear. When neither condition holds, `take` stays low and the status word is unchanged.
- R6: Taking a level-1 interrupt sets the exception-mode flag, keeps the level field, and makes the cause register (select 6) read 4.
- R7: The vector code is 0 for kernel, 1 for user and 2 for a level above one. A level-1 take reports 1 when the user-mode flag is set and 0 otherwise.
- R8: Taking a level L above one copies the old status word into the saved-status register of L (select 4, level L) and `ret_pc` into the saved-PC register of L (select 5, level L). The status then has the exception-mode flag set and level field L, and its other bits are kept, so its low five bits read 0x10 | L.
- R9: A return command for a level from 2 to 4 presents that level's saved PC on `rfi_pc` in the same cycle and loads its saved status into the status word at the next edge. A return command for any other level is ignored.
- R10: When several levels are pending and enabled, the highest level is taken first. For example, bits 7 and 11 together give a level-3 take.
- R11: A wait request sets the level field to its operand at the next edge and raises `stalled`. `stalled` stays high until an interrupt is taken, and it is low from the edge that completes the take.
- R12: The level of each interrupt bit is fixed: bits 0-9 are level 1, bits 10-13 are level 3, bits 14-21 are level 2 and bits 22-31 are level 4.
- R13: In a cycle where `take` is high, register writes, level-raise, return and wait commands are all dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for writes (codes in R1, R3, R6, R8) |
| reg_wr_lvl | input | 4 | Level for saved-state register writes |
| reg_wr_data | input | 32 | Write data or mask |
| reg_rd_sel | input | 3 | Register select for reads |
| reg_rd_lvl | input | 4 | Level for saved-state register reads |
| reg_rd_data | output | 32 | Combinational read data |
| raise_en | input | 1 | Level-raise command |
| raise_lvl | input | 4 | New level for the raise command |
| raise_old | output | 32 | Status word before the raise |
| rfi_en | input | 1 | Return-from-interrupt command |
| rfi_lvl | input | 4 | Level being returned from |
| rfi_pc | output | 32 | Saved return address of `rfi_lvl` |
| wait_en | input | 1 | Wait-for-interrupt request |
| wait_lvl | input | 4 | Level applied by the wait |
| stalled | output | 1 | Core is waiting for an interrupt |
| ret_pc | input | 32 | Return address saved on a high-level take |
| take | output | 1 | An interrupt is taken this cycle |
| take_vec | output | 2 | Entry vector code (R7) |
| take_lvl | output | 4 | Level of the interrupt being taken |
| cause | output | 6 | Cause register |

## Verification
The hardest cases to reach from the ports are the edges of the gating rule: a level-1 interrupt that is pending but held back only by the exception-mode flag, and a higher interrupt that is held back only by a level field equal to its own. The bench reaches them with a sweep. For every one of the 32 bits it programs every level field from 0 to 4 with the exception-mode flag both clear and set, and the user-mode and upper status bits are varied with the bit index. It then predicts the take, the vector, the resulting status and the saved state from R5 to R8 and R12. Directed sequences cover the wait stall while the enable word is zero, a take that arrives in the same cycle as competing commands, and returns through valid and invalid levels.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_N    = 32;
    localparam int IRQ_LW   = 4;
    localparam int IRQ_LMAX = 4;
    localparam int IRQ_XW   = 32;
    localparam int CAUSE_W  = 6;

    localparam logic [IRQ_XW-1:0]  STATUS_RST = 32'h0000_001F;
    localparam logic [CAUSE_W-1:0] CAUSE_L1   = 6'd4;

    typedef enum logic [2:0] {
        RS_PSET   = 3'd0,
        RS_PCLR   = 3'd1,
        RS_ENABLE = 3'd2,
        RS_STATUS = 3'd3,
        RS_SAVEPS = 3'd4,
        RS_SAVEPC = 3'd5,
        RS_CAUSE  = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_HIGH   = 2'd2
    } vec_e;

    typedef struct packed {
        logic [IRQ_XW-7:0] upper;
        logic              um;
        logic              excm;
        logic [IRQ_LW-1:0] lvl;
    } status_t;

    // fixed level assignment of every interrupt bit
    function automatic logic [IRQ_LW-1:0] irq_level(input int idx);
        if (idx < 10)      return IRQ_LW'(1);
        else if (idx < 14) return IRQ_LW'(3);
        else if (idx < 22) return IRQ_LW'(2);
        else               return IRQ_LW'(4);
    endfunction

    // all interrupt bits that sit at a given level
    function automatic logic [IRQ_N-1:0] lvl_mask(input logic [IRQ_LW-1:0] l);
        logic [IRQ_N-1:0] m;
        for (int i = 0; i < IRQ_N; i++) m[i] = (irq_level(i) == l);
        return m;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pkg::*;
#(
    parameter int NIRQ = IRQ_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_sel_e        wr_sel,
    input  logic [NIRQ-1:0] wr_data,
    output logic [NIRQ-1:0] pend,
    output logic [NIRQ-1:0] enab
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            enab <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                RS_PSET:   pend <= pend | wr_data;
                RS_PCLR:   pend <= pend & ~wr_data;
                RS_ENABLE: enab <= wr_data;
                default: ;
            endcase
        end
    end

    // R3: set bits appear, cleared bits vanish
    p_pend_set_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == RS_PSET |=> (pend & $past(wr_data)) == $past(wr_data));
    p_pend_clr_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == RS_PCLR |=> (pend & $past(wr_data)) == '0);

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_pkg::*;
#(
    parameter int NIRQ    = IRQ_N,
    parameter int LVL_W   = IRQ_LW,
    parameter int MAX_LVL = IRQ_LMAX
) (
    input  logic [NIRQ-1:0]  pend,
    input  logic [NIRQ-1:0]  enab,
    input  logic             excm,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             req,
    output logic [LVL_W-1:0] req_lvl
);

    logic [NIRQ-1:0]  live;
    logic [MAX_LVL:0] elig;

    assign live = pend & enab;

    generate
        for (genvar l = 0; l <= MAX_LVL; l++) begin : g_lvl
            if (l == 0) begin : g_none
                assign elig[l] = 1'b0;
            end else if (l == 1) begin : g_low
                // level 1 is masked while in exception mode
                assign elig[l] = |(live & lvl_mask(LVL_W'(l))) && !excm;
            end else begin : g_high
                assign elig[l] = |(live & lvl_mask(LVL_W'(l)));
            end
        end
    endgenerate

    always_comb begin
        req_lvl = '0;
        for (int l = 1; l <= MAX_LVL; l++) begin
            if (elig[l]) req_lvl = LVL_W'(l);
        end
    end

    assign req = (req_lvl > cur_lvl);

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
    import irq_pkg::*;
#(
    parameter int XW      = IRQ_XW,
    parameter int LVL_W   = IRQ_LW,
    parameter int MAX_LVL = IRQ_LMAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_en,
    input  logic [LVL_W-1:0] save_lvl,
    input  logic [XW-1:0]    save_ps,
    input  logic [XW-1:0]    save_pc,
    input  logic             sw_en,
    input  logic             sw_is_pc,
    input  logic [LVL_W-1:0] sw_lvl,
    input  logic [XW-1:0]    sw_data,
    input  logic [LVL_W-1:0] rd_lvl,
    output logic [XW-1:0]    rd_ps,
    output logic [XW-1:0]    rd_pc,
    input  logic [LVL_W-1:0] rfi_lvl,
    output logic [XW-1:0]    rfi_ps,
    output logic [XW-1:0]    rfi_pc
);

    logic [XW-1:0] ps_q [2:MAX_LVL];
    logic [XW-1:0] pc_q [2:MAX_LVL];

    always_ff @(posedge clk) begin
        for (int l = 2; l <= MAX_LVL; l++) begin
            if (rst) begin
                ps_q[l] <= '0;
                pc_q[l] <= '0;
            end else if (save_en && save_lvl == LVL_W'(l)) begin
                ps_q[l] <= save_ps;
                pc_q[l] <= save_pc;
            end else if (sw_en && sw_lvl == LVL_W'(l)) begin
                if (sw_is_pc) pc_q[l] <= sw_data;
                else          ps_q[l] <= sw_data;
            end
        end
    end

    always_comb begin
        rd_ps  = '0;
        rd_pc  = '0;
        rfi_ps = '0;
        rfi_pc = '0;
        for (int l = 2; l <= MAX_LVL; l++) begin
            if (rd_lvl == LVL_W'(l)) begin
                rd_ps = ps_q[l];
                rd_pc = pc_q[l];
            end
            if (rfi_lvl == LVL_W'(l)) begin
                rfi_ps = ps_q[l];
                rfi_pc = pc_q[l];
            end
        end
    end

    generate
        for (genvar l = 2; l <= MAX_LVL; l++) begin : g_chk
            // R8: entry captures status and return address of its own level
            p_entry_save_r8: assert property (@(posedge clk) disable iff (rst)
                save_en && save_lvl == LVL_W'(l) |=>
                    ps_q[l] == $past(save_ps) && pc_q[l] == $past(save_pc));
        end
    endgenerate

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int XW      = IRQ_XW,
    parameter int LVL_W   = IRQ_LW,
    parameter int MAX_LVL = IRQ_LMAX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [2:0]         reg_wr_sel,
    input  logic [LVL_W-1:0]   reg_wr_lvl,
    input  logic [XW-1:0]      reg_wr_data,
    input  logic [2:0]         reg_rd_sel,
    input  logic [LVL_W-1:0]   reg_rd_lvl,
    output logic [XW-1:0]      reg_rd_data,
    input  logic               raise_en,
    input  logic [LVL_W-1:0]   raise_lvl,
    output logic [XW-1:0]      raise_old,
    input  logic               rfi_en,
    input  logic [LVL_W-1:0]   rfi_lvl,
    output logic [XW-1:0]      rfi_pc,
    input  logic               wait_en,
    input  logic [LVL_W-1:0]   wait_lvl,
    output logic               stalled,
    input  logic [XW-1:0]      ret_pc,
    output logic               take,
    output logic [1:0]         take_vec,
    output logic [LVL_W-1:0]   take_lvl,
    output logic [CAUSE_W-1:0] cause
);

    localparam logic [LVL_W-1:0] LV_ONE = LVL_W'(1);
    localparam logic [LVL_W-1:0] LV_TOP = LVL_W'(MAX_LVL);

    status_t              st, st_n;
    logic [CAUSE_W-1:0]   cause_q, cause_n;
    logic                 waiting, wait_n;
    logic [IRQ_N-1:0]     pend, enab;
    logic                 req;
    logic [LVL_W-1:0]     best_lvl;
    logic [XW-1:0]        rd_ps, rd_pc, rfi_ps;
    logic                 wr_ok, rfi_ok, save_en;
    reg_sel_e             wsel, rsel;

    assign wsel   = reg_sel_e'(reg_wr_sel);
    assign rsel   = reg_sel_e'(reg_rd_sel);
    assign wr_ok  = reg_wr_en && !take;
    assign rfi_ok = (rfi_lvl > LV_ONE) && (rfi_lvl <= LV_TOP);

    irq_pend_bank #(.NIRQ(IRQ_N)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_sel  (wsel),
        .wr_data (reg_wr_data),
        .pend    (pend),
        .enab    (enab)
    );

    irq_level_arbiter #(.NIRQ(IRQ_N), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)) u_arb (
        .pend    (pend),
        .enab    (enab),
        .excm    (st.excm),
        .cur_lvl (st.lvl),
        .req     (req),
        .req_lvl (best_lvl)
    );

    assign take     = req;
    assign take_lvl = best_lvl;
    assign save_en  = take && (best_lvl > LV_ONE);

    irq_save_bank #(.XW(XW), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)) u_save (
        .clk      (clk),
        .rst      (rst),
        .save_en  (save_en),
        .save_lvl (best_lvl),
        .save_ps  (st),
        .save_pc  (ret_pc),
        .sw_en    (wr_ok && (wsel == RS_SAVEPS || wsel == RS_SAVEPC)),
        .sw_is_pc (wsel == RS_SAVEPC),
        .sw_lvl   (reg_wr_lvl),
        .sw_data  (reg_wr_data),
        .rd_lvl   (reg_rd_lvl),
        .rd_ps    (rd_ps),
        .rd_pc    (rd_pc),
        .rfi_lvl  (rfi_lvl),
        .rfi_ps   (rfi_ps),
        .rfi_pc   (rfi_pc)
    );

    // entry vector
    always_comb begin
        if (best_lvl > LV_ONE) take_vec = VEC_HIGH;
        else if (st.um)        take_vec = VEC_USER;
        else                   take_vec = VEC_KERNEL;
    end

    // status, cause and wait state; a take overrides every command
    always_comb begin
        st_n    = st;
        cause_n = cause_q;
        wait_n  = waiting;
        if (take) begin
            wait_n  = 1'b0;
            st_n.excm = 1'b1;
            if (best_lvl == LV_ONE) cause_n  = CAUSE_L1;
            else                    st_n.lvl = best_lvl;
        end else begin
            if (reg_wr_en && wsel == RS_STATUS) st_n    = status_t'(reg_wr_data);
            if (reg_wr_en && wsel == RS_CAUSE)  cause_n = reg_wr_data[CAUSE_W-1:0];
            if (raise_en)                       st_n.lvl = raise_lvl;
            if (rfi_en && rfi_ok)               st_n    = status_t'(rfi_ps);
            if (wait_en) begin
                st_n.lvl = wait_lvl;
                wait_n   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= status_t'(STATUS_RST);
            cause_q <= '0;
            waiting <= 1'b0;
        end else begin
            st      <= st_n;
            cause_q <= cause_n;
            waiting <= wait_n;
        end
    end

    assign raise_old = st;
    assign stalled   = waiting;
    assign cause     = cause_q;

    always_comb begin
        case (rsel)
            RS_PSET, RS_PCLR: reg_rd_data = pend;
            RS_ENABLE:        reg_rd_data = enab;
            RS_STATUS:        reg_rd_data = st;
            RS_SAVEPS:        reg_rd_data = rd_ps;
            RS_SAVEPC:        reg_rd_data = rd_pc;
            RS_CAUSE:         reg_rd_data = XW'(cause_q);
            default:          reg_rd_data = '0;
        endcase
    end

    // R4: a take always has an enabled pending bit at its level
    p_enabled_only_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> (pend & enab & lvl_mask(take_lvl)) != '0);

    // R5: gating by level field and exception mode
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> take_lvl > st.lvl && (take_lvl != LV_ONE || !st.excm));

    // R6: level-1 entry
    p_l1_entry_r6: assert property (@(posedge clk) disable iff (rst)
        take && take_lvl == LV_ONE |=>
            st.excm && st.lvl == $past(st.lvl) && cause_q == CAUSE_L1);

    // R8: high-level entry raises the level field
    p_high_entry_r8: assert property (@(posedge clk) disable iff (rst)
        take && take_lvl > LV_ONE |=>
            st.excm && st.lvl == $past(take_lvl) && st.um == $past(st.um));

    // R2: raise touches only the level field
    p_raise_r2: assert property (@(posedge clk) disable iff (rst)
        raise_en && !take && !rfi_en && !wait_en && !(reg_wr_en && wsel == RS_STATUS) |=>
            st.lvl == $past(raise_lvl) && st.upper == $past(st.upper)
            && st.um == $past(st.um) && st.excm == $past(st.excm));

    // R9: return restores the saved status
    p_rfi_r9: assert property (@(posedge clk) disable iff (rst)
        rfi_en && rfi_ok && !take && !wait_en |=> st == status_t'($past(rfi_ps)));

    // R11: wait stalls, take wakes
    p_wait_r11: assert property (@(posedge clk) disable iff (rst)
        wait_en && !take |=> stalled && st.lvl == $past(wait_lvl));
    p_wake_r11: assert property (@(posedge clk) disable iff (rst)
        take |=> !stalled);

    // R13: writes in a take cycle are dropped
    p_drop_r13: assert property (@(posedge clk) disable iff (rst)
        take |=> enab == $past(enab) && pend == $past(pend));

endmodule

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/100ps
module irq_level_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [3:0]  reg_wr_lvl = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_sel = '0;
    logic [3:0]  reg_rd_lvl = '0;
    logic [31:0] reg_rd_data;
    logic        raise_en = 1'b0;
    logic [3:0]  raise_lvl = '0;
    logic [31:0] raise_old;
    logic        rfi_en = 1'b0;
    logic [3:0]  rfi_lvl = '0;
    logic [31:0] rfi_pc;
    logic        wait_en = 1'b0;
    logic [3:0]  wait_lvl = '0;
    logic        stalled;
    logic [31:0] ret_pc = '0;
    logic        take;
    logic [1:0]  take_vec;
    logic [3:0]  take_lvl;
    logic [5:0]  cause;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] S_PSET = 3'd0, S_PCLR = 3'd1, S_EN = 3'd2, S_ST = 3'd3,
                           S_SPS = 3'd4, S_SPC = 3'd5, S_CAUSE = 3'd6;

    always #2.5 clk = ~clk;

    irq_level_ctrl u_irq_level_ctrl (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_lvl(reg_wr_lvl),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_lvl(reg_rd_lvl),
        .reg_rd_data(reg_rd_data), .raise_en(raise_en), .raise_lvl(raise_lvl),
        .raise_old(raise_old), .rfi_en(rfi_en), .rfi_lvl(rfi_lvl), .rfi_pc(rfi_pc),
        .wait_en(wait_en), .wait_lvl(wait_lvl), .stalled(stalled), .ret_pc(ret_pc),
        .take(take), .take_vec(take_vec), .take_lvl(take_lvl), .cause(cause)
    );

    // R12 level table, written from the requirement
    function automatic int exp_lvl(input int i);
        if (i < 10) return 1;
        if (i < 14) return 3;
        if (i < 22) return 2;
        return 4;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [3:0] l, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_lvl = l; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [3:0] l, output logic [31:0] d);
        reg_rd_sel = s; reg_rd_lvl = l;
        #0.3;
        d = reg_rd_data;
    endtask

    task automatic quiesce();
        wr(S_EN, 4'd0, 32'h0);
        wr(S_PCLR, 4'd0, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        rd(S_ST, 0, d);    chk("R1 status reset", d, 32'h1F);
        rd(S_PSET, 0, d);  chk("R1 pending reset", d, 32'h0);
        rd(S_EN, 0, d);    chk("R1 enable reset", d, 32'h0);
        rd(S_CAUSE, 0, d); chk("R1 cause reset", d, 32'h0);
        chk("R1 take reset", {31'd0, take}, 32'd0);
        chk("R11 stalled reset", {31'd0, stalled}, 32'd0);

        // R3 set/clear readback
        wr(S_PSET, 0, 32'hA5A5_0000);
        rd(S_PSET, 0, d); chk("R3 pending set", d, 32'hA5A5_0000);
        wr(S_PCLR, 0, 32'h0505_0000);
        rd(S_PCLR, 0, d); chk("R3 pending clear", d, 32'hA0A0_0000);

        // R4 disabled pending never taken
        quiesce();
        wr(S_ST, 0, 32'h0);
        wr(S_PSET, 0, 32'hFFFF_FFFF);
        #0.5; chk("R4 no take all pending disabled", {31'd0, take}, 32'd0);
        @(negedge clk); #0.5;
        rd(S_ST, 0, d); chk("R4 status untouched", d, 32'h0);

        // sweep: every bit, level field 0..4, exception flag 0/1 (R5..R8, R12)
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 5; c++) begin
                for (int x = 0; x < 2; x++) begin
                    logic [31:0] sv;
                    int          l;
                    bit          et;
                    sv = (i % 2 == 1 ? 32'h20 : 32'h0) | (x == 1 ? 32'h10 : 32'h0)
                       | ((i / 2) % 2 == 1 ? 32'h0004_0000 : 32'h0) | 32'(c);
                    ret_pc = 32'h4000_0000 + 32'(i * 64 + c * 4 + x);
                    quiesce();
                    wr(S_ST, 0, sv);
                    wr(S_EN, 0, 32'd1 << i);
                    wr(S_PSET, 0, 32'd1 << i);
                    #0.5;
                    l  = exp_lvl(i);
                    et = (l > c) && (l > 1 || x == 0);
                    chk("R5 take gate", {31'd0, take}, {31'd0, et});
                    if (et) begin
                        chk("R12 take level", {28'd0, take_lvl}, 32'(l));
                        chk("R7 vector", {30'd0, take_vec},
                            l > 1 ? 32'd2 : (i % 2 == 1 ? 32'd1 : 32'd0));
                    end
                    @(negedge clk); #0.5;
                    rd(S_ST, 0, d);
                    if (!et) chk("R5 status kept", d, sv);
                    else if (l == 1) begin
                        chk("R6 l1 status", d, sv | 32'h10);
                        rd(S_CAUSE, 0, d); chk("R6 cause", d, 32'd4);
                    end else begin
                        chk("R8 high status", d, (sv & ~32'h1F) | 32'h10 | 32'(l));
                        rd(S_SPS, 4'(l), d); chk("R8 saved status", d, sv);
                        rd(S_SPC, 4'(l), d); chk("R8 saved pc", d, ret_pc);
                    end
                    if (et) chk("R5 no retake", {31'd0, take}, 32'd0);
                end
            end
        end

        // R10 priority: bits 7 and 11 together
        quiesce();
        wr(S_ST, 0, 32'h0);
        wr(S_EN, 0, 32'h880);
        wr(S_PSET, 0, 32'h880);
        #0.5;
        chk("R10 take", {31'd0, take}, 32'd1);
        chk("R10 level 3 first", {28'd0, take_lvl}, 32'd3);
        chk("R7 high vector", {30'd0, take_vec}, 32'd2);
        @(negedge clk); #0.5;
        rd(S_ST, 0, d); chk("R10 status 0x13", d, 32'h13);
        chk("R10 level 1 held", {31'd0, take}, 32'd0);

        // R9 return from level 3
        wr(S_PCLR, 0, 32'hFFFF_FFFF);
        wr(S_SPS, 4'd3, 32'h0004_0003);
        wr(S_SPC, 4'd3, 32'h0000_1234);
        rfi_en = 1'b1; rfi_lvl = 4'd3;
        #0.5; chk("R9 rfi pc", rfi_pc, 32'h1234);
        @(negedge clk); rfi_en = 1'b0;
        #0.5; rd(S_ST, 0, d); chk("R9 status restored", d, 32'h0004_0003);
        rfi_en = 1'b1; rfi_lvl = 4'd1;
        @(negedge clk); rfi_en = 1'b0;
        #0.5; rd(S_ST, 0, d); chk("R9 bad level ignored", d, 32'h0004_0003);

        // R2 raise
        wr(S_ST, 0, 32'h0004_0025);
        raise_en = 1'b1; raise_lvl = 4'd7;
        #0.5; chk("R2 old status", raise_old, 32'h0004_0025);
        @(negedge clk); raise_en = 1'b0;
        #0.5; rd(S_ST, 0, d); chk("R2 new status", d, 32'h0004_0027);

        // R11 wait, stall, wake
        quiesce();
        wr(S_ST, 0, 32'h0F);
        wr(S_PSET, 0, 32'h80);
        wait_en = 1'b1; wait_lvl = 4'd0;
        @(negedge clk); wait_en = 1'b0;
        #0.5;
        chk("R11 stalled", {31'd0, stalled}, 32'd1);
        rd(S_ST, 0, d); chk("R11 level lowered", d, 32'h0);
        repeat (3) @(negedge clk);
        #0.5; chk("R11 still stalled", {31'd0, stalled}, 32'd1);
        chk("R4 no take while disabled", {31'd0, take}, 32'd0);
        wr(S_EN, 0, 32'h80);
        #0.5;
        chk("R11 wake take", {31'd0, take}, 32'd1);
        chk("R7 kernel vector", {30'd0, take_vec}, 32'd0);
        @(negedge clk); #0.5;
        chk("R11 stall released", {31'd0, stalled}, 32'd0);
        rd(S_ST, 0, d); chk("R11 status after wake", d, 32'h10);

        // R13 commands dropped during take
        quiesce();
        wr(S_ST, 0, 32'h0);
        wr(S_EN, 0, 32'h80);
        wr(S_PSET, 0, 32'h80);
        #0.5; chk("R13 take present", {31'd0, take}, 32'd1);
        raise_en = 1'b1; raise_lvl = 4'd9;
        wait_en = 1'b1; wait_lvl = 4'd2;
        reg_wr_en = 1'b1; reg_wr_sel = S_EN; reg_wr_data = 32'h0;
        @(negedge clk);
        raise_en = 1'b0; wait_en = 1'b0; reg_wr_en = 1'b0;
        #0.5;
        rd(S_ST, 0, d); chk("R13 status from take only", d, 32'h10);
        rd(S_EN, 0, d); chk("R13 enable write dropped", d, 32'h80);
        chk("R13 wait dropped", {31'd0, stalled}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule